// File: doc/BRIEF.md
# Infrared Link Host Register Bank

This block is the byte-wide host register file of a serial infrared link controller. A host issues 8-bit read and write strobes at small offsets from the port base. The block keeps the DMA ring base pointer in three byte registers and presents it to the DMA engine as a 32-bit address aligned to a 1 KB boundary.

The block also keeps a sticky interrupt status register and a matching interrupt enable register. One-cycle event pulses from the transmit, receive and FIFO logic set the status bits. The host clears a status bit by writing a one to it. A single interrupt request line is high while any enabled status bit is set.

Top module: `irlink_host_regs`

## Requirements
- R1: A write to offset 0x04 sets `ring_base[17:10]` and a write to offset 0x05 sets `ring_base[25:18]`. Both offsets read back the value that was written.
- R2: A write to offset 0x02 sets `ring_base[31:26]` from data bits 5..0. A read of 0x02 returns those six bits in bits 5..0, with bits 7..6 as zero.
- R3: `ring_base[9:0]` is zero at all times.
- R4: Offset 0x0C reads the status register. Bit 7 is transmit done, set by `evt_in[4]`. Bit 6 is receive done, set by `evt_in[3]`. Bit 5 is transmit underflow, set by `evt_in[2]`. Bit 4 is receive overflow, set by `evt_in[1]`. Bit 3 is serial gap, set by `evt_in[0]`. Bits 2..0 always read 1.
- R5: A one-cycle high on an `evt_in` bit sets its status bit at the next clock edge. The bit stays set until it is cleared.
- R6: Writing 0x0C clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R7: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: Offset 0x0D is the enable register, with the same bit layout as the status register. A write stores data bits 7..3, and a read returns them with bits 2..0 as zero.
- R9: `irq` is high exactly when the bitwise AND of status bits 7..3 and enable bits 7..3 is nonzero.
- R10: A read of any other offset returns 0x00. A write to any other offset changes no register.
- R11: Reset clears the ring pointer, the status bits, the enable bits and `host_rdata`, and drives `irq` low.
- R12: `host_rdata` is updated on the clock edge where `host_rd` is high, so it is valid one cycle after the strobe. It holds its value while `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Byte offset from the port base |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| evt_in | input | 5 | Event pulses: 4 tx done, 3 rx done, 2 tx underflow, 1 rx overflow, 0 serial gap |
| ring_base | output | 32 | Ring descriptor base address, 1 KB aligned |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes walking and alternating patterns to the three pointer bytes.
- If the byte lanes were swapped or the high byte were placed wrongly, the upper address bits would land in the wrong place.
- If the top two bits of offset 0x02 were not masked, a read of that offset would return ones there.

The bench drives an event pulse and a clearing write to the same status bit in the same cycle.
- A design that let the clear win would read that bit back as zero.
- A design that ignored zeros in the clear mask would lose bits that the host did not clear.

The bench checks `irq` with enable masks that overlap the pending events and with masks that do not, so a missing AND would show up. The last test writes to an unused offset and reads the unused offsets, to catch stray decode or ghost registers.

// File: rtl/irlink_regs_pkg.sv
package irlink_regs_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int NUM_EVT  = 5;
  localparam int EVT_LSB  = DATA_W - NUM_EVT;  // status bit of evt_in[0]
  localparam int PTR_W    = 32;
  localparam int ALIGN_W  = 10;

  localparam int OFF_PTR_HI  = 'h02;
  localparam int OFF_PTR_LO  = 'h04;
  localparam int OFF_PTR_MID = 'h05;
  localparam int OFF_STS     = 'h0C;
  localparam int OFF_EN      = 'h0D;

  typedef struct packed {
    logic ptr_hi;
    logic ptr_lo;
    logic ptr_mid;
    logic sts;
    logic en;
  } reg_sel_t;
endpackage

// File: rtl/irlink_addr_dec.sv
module irlink_addr_dec
  import irlink_regs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);
  always_comb begin
    sel         = '0;
    sel.ptr_hi  = (addr == AW'(OFF_PTR_HI));
    sel.ptr_lo  = (addr == AW'(OFF_PTR_LO));
    sel.ptr_mid = (addr == AW'(OFF_PTR_MID));
    sel.sts     = (addr == AW'(OFF_STS));
    sel.en      = (addr == AW'(OFF_EN));
  end
endmodule

// File: rtl/irlink_ring_ptr.sv
module irlink_ring_ptr
  import irlink_regs_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PTR_W,
  parameter int AL = ALIGN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_mid,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_lo,
  output logic [DW-1:0] rd_mid,
  output logic [DW-1:0] rd_hi,
  output logic [PW-1:0] base
);
  localparam int HI_W = PW - AL - 2 * DW;

  logic [DW-1:0]   lo_q, mid_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
    end else begin
      if (wr_lo)  lo_q  <= wdata;
      if (wr_mid) mid_q <= wdata;
      if (wr_hi)  hi_q  <= wdata[HI_W-1:0];
    end
  end

  assign rd_lo  = lo_q;
  assign rd_mid = mid_q;
  assign rd_hi  = DW'(hi_q);
  assign base   = {hi_q, mid_q, lo_q, {AL{1'b0}}};

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_lo || wr_mid || wr_hi) |=> $stable(base));
  // R1
  ptr_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (base[AL +: DW] == $past(wdata)));
endmodule

// File: rtl/irlink_irq_regs.sv
module irlink_irq_regs
  import irlink_regs_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NE = NUM_EVT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sts,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [NE-1:0] evt_in,
  output logic [DW-1:0] rd_sts,
  output logic [DW-1:0] rd_en,
  output logic          irq
);
  localparam int LSB = DW - NE;

  logic [NE-1:0] sts_q, en_q, clr_mask;

  assign clr_mask = wr_sts ? wdata[DW-1:LSB] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_mask) | evt_in;
      if (wr_en) en_q <= wdata[DW-1:LSB];
    end
  end

  assign rd_sts = {sts_q, {LSB{1'b1}}};
  assign rd_en  = {en_q, {LSB{1'b0}}};
  assign irq    = |(sts_q & en_q);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_mask)) & ~sts_q) == '0));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_in != '0) |=> ((sts_q & $past(evt_in)) == $past(evt_in)));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0 && evt_in == '0) |=> ((sts_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/irlink_host_regs.sv
module irlink_host_regs
  import irlink_regs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NE = NUM_EVT,
  parameter int PW = PTR_W,
  parameter int AL = ALIGN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic [NE-1:0] evt_in,
  output logic [PW-1:0] ring_base,
  output logic          irq
);
  reg_sel_t      sel;
  logic [DW-1:0] rd_lo, rd_mid, rd_hi, rd_sts, rd_en, rd_mux;

  irlink_addr_dec #(.AW(AW)) u_dec (.addr(host_addr), .sel(sel));

  irlink_ring_ptr #(.DW(DW), .PW(PW), .AL(AL)) u_ptr (
    .clk(clk), .rst(rst),
    .wr_lo(host_wr && sel.ptr_lo),
    .wr_mid(host_wr && sel.ptr_mid),
    .wr_hi(host_wr && sel.ptr_hi),
    .wdata(host_wdata),
    .rd_lo(rd_lo), .rd_mid(rd_mid), .rd_hi(rd_hi),
    .base(ring_base)
  );

  irlink_irq_regs #(.DW(DW), .NE(NE)) u_irq (
    .clk(clk), .rst(rst),
    .wr_sts(host_wr && sel.sts),
    .wr_en(host_wr && sel.en),
    .wdata(host_wdata),
    .evt_in(evt_in),
    .rd_sts(rd_sts), .rd_en(rd_en),
    .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.ptr_lo)  rd_mux = rd_lo;
    if (sel.ptr_mid) rd_mux = rd_mid;
    if (sel.ptr_hi)  rd_mux = rd_hi;
    if (sel.sts)     rd_mux = rd_sts;
    if (sel.en)      rd_mux = rd_en;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
  // R11
  reset_irq_low_chk: assert property (@(posedge clk)
    rst |=> !irq);
  // R3
  align_chk: assert property (@(posedge clk) disable iff (rst)
    ring_base[AL-1:0] == '0);
endmodule

// File: tb/test_irlink_host_regs.sv
module test_irlink_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic [4:0] evt_in = '0;
  logic [31:0] ring_base;
  logic       irq;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irlink_host_regs i_irlink_host_regs (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .evt_in(evt_in), .ring_base(ring_base), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R11 rdata", 32'(host_rdata), 0);
    chk("R11 ring_base", ring_base, 0);
    chk("R11 irq", 32'(irq), 0);
    rd(5'h0C, d); chk("R11 status", 32'(d), 32'h07);
    rd(5'h0D, d); chk("R11 enable", 32'(d), 32'h00);
  endtask

  task automatic t_ring;
    logic [7:0] d;
    wr(5'h04, 8'hA5); wr(5'h05, 8'h3C); wr(5'h02, 8'hFF);
    chk("R1 R2 ring_base", ring_base, {6'h3F, 8'h3C, 8'hA5, 10'h0});
    chk("R3 low bits", 32'(ring_base[9:0]), 0);
    rd(5'h04, d); chk("R1 read 0x04", 32'(d), 32'hA5);
    rd(5'h05, d); chk("R1 read 0x05", 32'(d), 32'h3C);
    rd(5'h02, d); chk("R2 read 0x02", 32'(d), 32'h3F);
    wr(5'h02, 8'hD5); wr(5'h04, 8'h01); wr(5'h05, 8'h80);
    chk("R1 R2 ring_base walk", ring_base, {6'h15, 8'h80, 8'h01, 10'h0});
  endtask

  task automatic t_status;
    logic [7:0] d;
    pulse(5'b10000);
    rd(5'h0C, d); chk("R4 R5 tx done bit7", 32'(d), 32'h87);
    pulse(5'b00001);
    rd(5'h0C, d); chk("R4 R5 gap bit3", 32'(d), 32'h8F);
    pulse(5'b01110);
    rd(5'h0C, d); chk("R4 all bits", 32'(d), 32'hFF);
    wr(5'h0C, 8'h48);
    rd(5'h0C, d); chk("R6 partial clear", 32'(d), 32'hB7);
    wr(5'h0C, 8'h00);
    rd(5'h0C, d); chk("R6 zero write no effect", 32'(d), 32'hB7);
    wr(5'h0C, 8'hFF);
    rd(5'h0C, d); chk("R6 full clear", 32'(d), 32'h07);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    @(negedge clk);
    evt_in = 5'b01000; host_addr = 5'h0C; host_wdata = 8'hC0; host_wr = 1'b1;
    @(negedge clk);
    evt_in = '0; host_wr = 1'b0;
    rd(5'h0C, d); chk("R7 set wins", 32'(d), 32'h47);
    wr(5'h0C, 8'hF8);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(5'h0D, 8'hFF);
    rd(5'h0D, d); chk("R8 enable read", 32'(d), 32'hF8);
    chk("R9 no pending", 32'(irq), 0);
    wr(5'h0D, 8'h20);
    pulse(5'b00010);
    chk("R9 disjoint mask", 32'(irq), 0);
    pulse(5'b00100);
    chk("R9 overlap", 32'(irq), 1);
    wr(5'h0C, 8'h20);
    chk("R9 cleared", 32'(irq), 0);
    wr(5'h0D, 8'h10);
    chk("R9 late enable", 32'(irq), 1);
    wr(5'h0C, 8'hF8); wr(5'h0D, 8'h00);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    logic [31:0] rb;
    rb = ring_base;
    wr(5'h03, 8'hFF); wr(5'h1F, 8'hFF);
    chk("R10 ring unchanged", ring_base, rb);
    rd(5'h0C, d); chk("R10 status unchanged", 32'(d), 32'h07);
    rd(5'h0D, d); chk("R10 enable unchanged", 32'(d), 32'h00);
    rd(5'h03, d); chk("R10 read 0x03", 32'(d), 0);
    rd(5'h1F, d); chk("R10 read 0x1F", 32'(d), 0);
    rd(5'h04, d);
    @(negedge clk); host_addr = 5'h0C;
    @(negedge clk);
    chk("R12 hold without strobe", 32'(host_rdata), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ring();
    t_status();
    t_set_wins();
    t_irq();
    t_unimpl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule